// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

A 32-bit arithmetic unit for signal-processing datapaths. It computes results whose out-of-range values are pinned to a limit rather than wrapped. An opcode input picks one of ten operations. The choices are:

- signed and unsigned saturating add and subtract;
- signed saturating doubling;
- a wrapping add that still reports signed overflow;
- clamping of a word to a selectable signed or unsigned bit width;
- the same clamping applied to two 16-bit halfword lanes at once.

The result and a one-cycle saturation indication are purely combinational. A single registered sticky flag collects every saturation event until it is explicitly cleared. Operand B is used only by the add and subtract operations. The width field is used only by the clamping operations.

Top module: `sat_alu`

## Requirements
- R1: Signed add (opcode 0). Overflow is when the sum's sign differs from A's sign and A and B share a sign. On overflow the result is 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative, and `sat_o` is 1. Otherwise the result is A+B and `sat_o` is 0.
- R2: Signed subtract (opcode 1). Overflow is when A-B has a sign other than A's and A and B have different signs. The result clamps by A's sign as in R1 and `sat_o` is 1. Otherwise the result is A-B.
- R3: Flagging add (opcode 5) always returns the wrapped sum A+B. `sat_o` is 1 exactly on the signed overflow condition of R1.
- R4: Doubling (opcode 2) acts on A. If A is at least 0x40000000 the result is 0x7FFFFFFF. If A, read as signed, is at most 0xC0000000 the result is 0x80000000. Both of these set `sat_o`. Otherwise the result is 2*A.
- R5: Unsigned add (opcode 3) gives 0xFFFFFFFF with `sat_o` when the sum wraps. Unsigned subtract (opcode 4) gives 0 with `sat_o` when B exceeds A.
- R6: Signed width clamp (opcode 6) limits signed A to the range -(2^s) to 2^s-1, where s is `width_i` (0..31). `sat_o` is 1 when A lies outside that range.
- R7: Unsigned width clamp (opcode 7) gives 0 for negative A and 2^s-1 for A above 2^s-1. `sat_o` is 1 when either limit applies.
- R8: Halfword clamps (opcode 8 signed, opcode 9 unsigned) sign-extend bits 15:0 and 31:16 as separate lanes. Each lane is clamped as in R6/R7 and the low 16 bits of each lane result go back into the same lane. `width_i` values 16..31 act as 15. `sat_o` is 1 if either lane clamps.
- R9: `q_o` is 0 after reset. One clock after any cycle with `sat_o` high, `q_o` is 1. `q_o` otherwise holds, except that `q_clr_i` clears it on the next clock. A saturation in the same cycle as a clear leaves `q_o` set.
- R10: Opcodes 10..15 give a result of 0 with `sat_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| width_i | input | 5 | Clamp width s |
| q_clr_i | input | 1 | Synchronous clear of the sticky flag |
| res_o | output | 32 | Result |
| sat_o | output | 1 | Saturation occurred this cycle |
| q_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit at its default 32-bit word, so each dual-lane operation runs on 16-bit lanes. At that size a width code above 15 sends the halfword path through its clipping branch. A width of 31 reaches the point where the full-word signed clamp can never trigger. The fixed 0x40000000 and 0xC0000000 doubling thresholds and the 0x7FFFFFFF/0x80000000 limits are the exact corner values the vectors probe.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned N_LANES = 2;
    localparam int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_SDBL  = 4'd2,
        OP_UADD  = 4'd3,
        OP_USUB  = 4'd4,
        OP_ADDQ  = 4'd5,
        OP_SSATW = 4'd6,
        OP_USATW = 4'd7,
        OP_SSATH = 4'd8,
        OP_USATH = 4'd9
    } sat_op_e;

    // Operation class used by the output selector.
    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_WORD,
        CLS_LANE,
        CLS_NONE
    } op_class_e;

    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        case (op)
            OP_SADD, OP_SSUB, OP_SDBL, OP_UADD, OP_USUB, OP_ADDQ: return CLS_ARITH;
            OP_SSATW, OP_USATW:                                   return CLS_WORD;
            OP_SSATH, OP_USATH:                                   return CLS_LANE;
            default:                                              return CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res,
    output logic            sat
);
    localparam logic [W-1:0] SMAX   = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN   = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] DBL_HI = {2'b01, {(W-2){1'b0}}};
    localparam logic [W-1:0] DBL_LO = {2'b11, {(W-2){1'b0}}};

    logic [W-1:0] sum, dif, sclamp;
    logic         add_ovf, sub_ovf, dbl_pos, dbl_neg;

    always_comb begin
        sum     = a + b;
        dif     = a - b;
        add_ovf = (sum[W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
        sub_ovf = (dif[W-1] ^ a[W-1]) &  (a[W-1] ^ b[W-1]);
        sclamp  = a[W-1] ? SMIN : SMAX;
        dbl_pos = !a[W-1] && (a >= DBL_HI);
        dbl_neg =  a[W-1] && (a <= DBL_LO);
    end

    always_comb begin
        res = '0;
        sat = 1'b0;
        case (sat_op_e'(op))
            OP_SADD: begin
                sat = add_ovf;
                res = add_ovf ? sclamp : sum;
            end
            OP_SSUB: begin
                sat = sub_ovf;
                res = sub_ovf ? sclamp : dif;
            end
            OP_ADDQ: begin
                sat = add_ovf;
                res = sum;
            end
            OP_SDBL: begin
                sat = dbl_pos | dbl_neg;
                res = dbl_pos ? SMAX : (dbl_neg ? SMIN : {a[W-2:0], 1'b0});
            end
            OP_UADD: begin
                sat = sum < a;
                res = sat ? {W{1'b1}} : sum;
            end
            OP_USUB: begin
                sat = b > a;
                res = sat ? '0 : dif;
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int unsigned W   = 32,
    parameter int unsigned S_W = $clog2(W)
) (
    input  logic [W-1:0]   v,
    input  logic [S_W-1:0] s,
    input  logic           is_signed,
    output logic [W-1:0]   res,
    output logic           sat
);
    logic signed [W:0] vx, lim, hi, lo;

    always_comb begin
        vx  = {v[W-1], v};
        lim = {{W{1'b0}}, 1'b1} << s;
        hi  = lim - 1'b1;
        lo  = -lim;
        res = v;
        sat = 1'b0;
        if (is_signed) begin
            if (vx > hi) begin
                res = hi[W-1:0];
                sat = 1'b1;
            end else if (vx < lo) begin
                res = lo[W-1:0];
                sat = 1'b1;
            end
        end else begin
            if (v[W-1]) begin
                res = '0;
                sat = 1'b1;
            end else if (vx > hi) begin
                res = hi[W-1:0];
                sat = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LANES  = N_LANES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [OP_W-1:0]             op_i,
    input  logic [DATA_W-1:0]           a_i,
    input  logic [DATA_W-1:0]           b_i,
    input  logic [$clog2(DATA_W)-1:0]   width_i,
    input  logic                        q_clr_i,
    output logic [DATA_W-1:0]           res_o,
    output logic                        sat_o,
    output logic                        q_o
);
    localparam int unsigned WID_W  = $clog2(DATA_W);
    localparam int unsigned LANE_W = DATA_W / LANES;
    localparam int unsigned LS_W   = $clog2(LANE_W);

    logic [DATA_W-1:0] ar_res, wd_res, ln_res;
    logic              ar_sat, wd_sat;
    logic [LANES-1:0]  ln_sat;
    logic [LS_W-1:0]   lane_s;
    op_class_e         cls;
    logic              q_q;

    assign cls = classify(op_i);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .op (op_i),
        .a  (a_i),
        .b  (b_i),
        .res(ar_res),
        .sat(ar_sat)
    );

    sat_clamp #(.W(DATA_W), .S_W(WID_W)) u_word (
        .v        (a_i),
        .s        (width_i),
        .is_signed(op_i == OP_SSATW),
        .res      (wd_res),
        .sat      (wd_sat)
    );

    // Lane widths beyond the lane maximum act as the maximum.
    assign lane_s = (width_i > WID_W'(LANE_W - 1)) ? LS_W'(LANE_W - 1)
                                                   : width_i[LS_W-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sat_clamp #(.W(LANE_W), .S_W(LS_W)) u_lane (
            .v        (a_i[l*LANE_W +: LANE_W]),
            .s        (lane_s),
            .is_signed(op_i == OP_SSATH),
            .res      (ln_res[l*LANE_W +: LANE_W]),
            .sat      (ln_sat[l])
        );
    end

    always_comb begin
        case (cls)
            CLS_ARITH: begin res_o = ar_res; sat_o = ar_sat;  end
            CLS_WORD:  begin res_o = wd_res; sat_o = wd_sat;  end
            CLS_LANE:  begin res_o = ln_res; sat_o = |ln_sat; end
            default:   begin res_o = '0;     sat_o = 1'b0;    end
        endcase
    end

    // Sticky flag: a saturation in the clearing cycle wins.
    always_ff @(posedge clk) begin
        if (rst) q_q <= 1'b0;
        else     q_q <= (q_q & ~q_clr_i) | sat_o;
    end

    assign q_o = q_q;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
    import sat_alu_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              q_clr_i,
    input logic [DATA_W-1:0] res_o,
    input logic              sat_o,
    input logic              q_o
);
    p_q_set_r9: assert property (@(posedge clk) disable iff (rst)
        sat_o |=> q_o);

    p_q_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!sat_o && !q_clr_i) |=> $stable(q_o));

    p_q_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (q_clr_i && !sat_o) |=> !q_o);

    p_wrap_sum_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADDQ) |-> (res_o == a_i + b_i));

    p_usat_add_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_UADD && sat_o) |-> (res_o == {DATA_W{1'b1}}));

    p_usat_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_USUB && sat_o) |-> (res_o == '0));

    p_sadd_limit_r1: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SADD && sat_o) |-> (res_o[DATA_W-1] == a_i[DATA_W-1]));

    p_idle_op_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_USATH) |-> (res_o == '0 && !sat_o));
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_sat_alu_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .q_clr_i(q_clr_i),
    .res_o  (res_o),
    .sat_o  (sat_o),
    .q_o    (q_o)
);

// File: tb/test_sat_alu.sv
`timescale 1ns/1ps
module test_sat_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [4:0]  width_i = '0;
    logic        q_clr_i = 1'b0;
    logic [31:0] res_o;
    logic        sat_o, q_o;

    int errs = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sat_alu i_sat_alu (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .width_i(width_i), .q_clr_i(q_clr_i),
        .res_o(res_o), .sat_o(sat_o), .q_o(q_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  w;
        logic [31:0] res;
        logic        sat;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  4'h0, 32'h00000001, 32'h00000002, 5'd0,  32'h00000003, 1'b0}, // R1
        '{4'd1,  4'h0, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1}, // R1
        '{4'd1,  4'h0, 32'h80000000, 32'hFFFFFFFF, 5'd0,  32'h80000000, 1'b1}, // R1
        '{4'd2,  4'h1, 32'h80000000, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R2
        '{4'd2,  4'h1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h7FFFFFFF, 1'b1}, // R2
        '{4'd2,  4'h1, 32'h00000005, 32'h00000007, 5'd0,  32'hFFFFFFFE, 1'b0}, // R2
        '{4'd3,  4'h5, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R3
        '{4'd3,  4'h5, 32'h0000000A, 32'h00000014, 5'd0,  32'h0000001E, 1'b0}, // R3
        '{4'd4,  4'h2, 32'h40000000, 32'h00000000, 5'd0,  32'h7FFFFFFF, 1'b1}, // R4
        '{4'd4,  4'h2, 32'h3FFFFFFF, 32'h00000000, 5'd0,  32'h7FFFFFFE, 1'b0}, // R4
        '{4'd4,  4'h2, 32'hC0000000, 32'h00000000, 5'd0,  32'h80000000, 1'b1}, // R4
        '{4'd4,  4'h2, 32'hC0000001, 32'h00000000, 5'd0,  32'h80000002, 1'b0}, // R4
        '{4'd5,  4'h3, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'hFFFFFFFF, 1'b1}, // R5
        '{4'd5,  4'h3, 32'h00000001, 32'h00000002, 5'd0,  32'h00000003, 1'b0}, // R5
        '{4'd5,  4'h4, 32'h00000001, 32'h00000002, 5'd0,  32'h00000000, 1'b1}, // R5
        '{4'd5,  4'h4, 32'h00000005, 32'h00000005, 5'd0,  32'h00000000, 1'b0}, // R5
        '{4'd6,  4'h6, 32'h00000100, 32'h0,        5'd7,  32'h0000007F, 1'b1}, // R6
        '{4'd6,  4'h6, 32'hFFFFFF00, 32'h0,        5'd7,  32'hFFFFFF80, 1'b1}, // R6
        '{4'd6,  4'h6, 32'h00000050, 32'h0,        5'd7,  32'h00000050, 1'b0}, // R6
        '{4'd6,  4'h6, 32'h80000000, 32'h0,        5'd31, 32'h80000000, 1'b0}, // R6
        '{4'd6,  4'h6, 32'h00000005, 32'h0,        5'd0,  32'h00000000, 1'b1}, // R6
        '{4'd7,  4'h7, 32'hFFFFFFFF, 32'h0,        5'd8,  32'h00000000, 1'b1}, // R7
        '{4'd7,  4'h7, 32'h00000300, 32'h0,        5'd8,  32'h000000FF, 1'b1}, // R7
        '{4'd7,  4'h7, 32'h7FFFFFFF, 32'h0,        5'd31, 32'h7FFFFFFF, 1'b0}, // R7
        '{4'd7,  4'h7, 32'h00000080, 32'h0,        5'd8,  32'h00000080, 1'b0}, // R7
        '{4'd8,  4'h8, 32'h7FFF8000, 32'h0,        5'd7,  32'h007FFF80, 1'b1}, // R8
        '{4'd8,  4'h8, 32'h12345678, 32'h0,        5'd20, 32'h12345678, 1'b0}, // R8
        '{4'd8,  4'h8, 32'h00050200, 32'h0,        5'd7,  32'h0005007F, 1'b1}, // R8
        '{4'd8,  4'h9, 32'h80000100, 32'h0,        5'd8,  32'h000000FF, 1'b1}, // R8
        '{4'd8,  4'h9, 32'h7FFF0001, 32'h0,        5'd31, 32'h7FFF0001, 1'b0}, // R8
        '{4'd10, 4'hA, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  32'h00000000, 1'b0}, // R10
        '{4'd10, 4'hF, 32'h7FFFFFFF, 32'h00000001, 5'd3,  32'h00000000, 1'b0}  // R10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [4:0] w,
                         input logic clr);
        @(negedge clk);
        op_i = op; a_i = a; b_i = 32'h1; width_i = w; q_clr_i = clr;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 q in reset", {31'b0, q_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 q after reset", {31'b0, q_o}, 32'h0);
        chk("R1 idle result", res_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_i = VECS[i].op; a_i = VECS[i].a; b_i = VECS[i].b; width_i = VECS[i].w;
            #1;
            chk($sformatf("R%0d vec%0d res", VECS[i].req, i), res_o, VECS[i].res);
            chk($sformatf("R%0d vec%0d sat", VECS[i].req, i), {31'b0, sat_o}, {31'b0, VECS[i].sat});
        end

        // R9: clear with no saturation empties the flag
        drive(4'h0, 32'h1, 5'd0, 1'b1);
        @(posedge clk); #1;
        chk("R9 cleared", {31'b0, q_o}, 32'h0);
        // R9: one saturating cycle sets it
        drive(4'h0, 32'h7FFFFFFF, 5'd0, 1'b0);
        @(posedge clk); #1;
        chk("R9 set", {31'b0, q_o}, 32'h1);
        // R9: flag holds across quiet cycles
        drive(4'h0, 32'h1, 5'd0, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 held", {31'b0, q_o}, 32'h1);
        // R9: saturation during clear keeps it set
        drive(4'h0, 32'h7FFFFFFF, 5'd0, 1'b1);
        @(posedge clk); #1;
        chk("R9 set beats clear", {31'b0, q_o}, 32'h1);
        // R9: clear alone empties it
        drive(4'h0, 32'h1, 5'd0, 1'b1);
        @(posedge clk); #1;
        chk("R9 cleared again", {31'b0, q_o}, 32'h0);
        // R3: flagging add also sets the sticky flag
        drive(4'h5, 32'h7FFFFFFF, 5'd0, 1'b0);
        @(posedge clk); #1;
        chk("R3 sets q", {31'b0, q_o}, 32'h1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule